// File: doc/BRIEF.md
# Dual-Channel CAN Interrupt Aggregator

This block sits between two CAN controller channels and the processor's interrupt controller. Each channel reports completed transmissions and receptions as single-cycle pulses tagged with a message-slot index (sixteen slots per channel). The block records the slot in a per-channel completion register and gates it through a per-slot enable register. It drives one transmit-done and one receive-done request line per channel. Software reads the completion register to find which mailbox finished, then clears that bit.

Fault-confinement changes from both channels feed one shared error request. These are entering the error-passive state, entering the bus-off state, and individual bus errors. Each channel can mute its bus-error source on its own. Wake-up events from either channel, seen while the processor is in a low-power mode, raise a shared wake-up request. A small register port gives access to the enables, completion bits, controls, shared pending bits and both channels' error counters. Reads have no side effects.

Top module: `can_irq_agg`

## Requirements
- R1: A `tx_done[c]` pulse with slot index `s` on `tx_slot[4c+3:4c]` sets bit `s` of channel `c`'s transmit completion register on that clock edge, and the bit is readable right after it. `rx_done`/`rx_slot` do the same for the receive completion register. Other bits are unchanged.
- R2: `irq_tx[c]` is high exactly while some bit is set in both channel `c`'s transmit completion register and its slot-enable register (bit `s` enables slot `s`). `irq_rx[c]` follows the same rule with the receive completion register. Clearing an enable bit drops the line without losing the completion bit.
- R3: Writing to a completion register clears each bit written as 1 and leaves bits written as 0 alone. If a slot's event and its clear fall in the same cycle, the bit ends up set.
- R4: A rising edge on `err_passive[c]` or `bus_off[c]` sets the shared error pending bit. A level that stays high does not set it again after it is cleared.
- R5: A `bus_err[c]` pulse sets the shared error pending bit unless bit 0 of channel `c`'s control register is 1. That control bit mutes only that channel's bus errors.
- R6: A `wake_evt[c]` pulse sets the wake pending bit only while `low_power` is high. Otherwise it has no effect.
- R7: The shared pending register at address 8 holds the error bit (bit 0, drives `irq_err`) and the wake bit (bit 1, drives `irq_wake`). Both are write-one-to-clear, and a set wins over a same-cycle clear.
- R8: Address 9 reads channel 0's error counters and address 10 reads channel 1's. The transmit counter is in bits 15:8 and the receive counter in bits 7:0.
- R9: Channel `c` owns addresses 4c to 4c+3: slot enable (read/write) at 4c, transmit completion at 4c+1, receive completion at 4c+2, and control at 4c+3 (only bit 0 is stored; the other bits read 0). Unmapped addresses read 0, and reading never changes state.
- R10: After reset, all registers read 0 and all six request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | 2 | Per-channel transmit-complete pulse |
| tx_slot | input | 8 | Slot index of the transmit event, 4 bits per channel |
| rx_done | input | 2 | Per-channel receive-complete pulse |
| rx_slot | input | 8 | Slot index of the receive event, 4 bits per channel |
| err_passive | input | 2 | Per-channel error-passive state level |
| bus_off | input | 2 | Per-channel bus-off state level |
| bus_err | input | 2 | Per-channel bus error pulse |
| wake_evt | input | 2 | Per-channel wake-up event pulse |
| low_power | input | 1 | Processor is in a low-power mode |
| rx_err_cnt | input | 16 | Receive error counters, 8 bits per channel |
| tx_err_cnt | input | 16 | Transmit error counters, 8 bits per channel |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_tx | output | 2 | Per-channel transmit-done request |
| irq_rx | output | 2 | Per-channel receive-done request |
| irq_err | output | 1 | Shared error request |
| irq_wake | output | 1 | Shared wake-up request |

## Verification
The bench drives an event and a write-one-to-clear on the same slot in the same cycle. A design that lets the clear win would lose a completion and leave a mailbox unserviced. It holds error-passive high across a clear of the error bit. Level-triggered logic would re-raise the request at once and flood the processor. It mutes bus errors on one channel and then pulses the other channel, and sends wake events outside low-power mode. These catch a mute that spans both channels, or a wake line that ignores the mode. It also drops a slot enable while a completion is pending, to catch designs that gate the recording instead of the request.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int CH_N        = 2;
    localparam int SLOT_N      = 16;
    localparam int SLOT_W      = $clog2(SLOT_N);
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 4;
    localparam int ERRC_W      = 8;
    localparam int REGS_PER_CH = 4;

    // per-channel register offsets inside a channel window
    typedef enum logic [1:0] {
        OFS_SLOT_EN = 2'd0,
        OFS_TX_DONE = 2'd1,
        OFS_RX_DONE = 2'd2,
        OFS_CTRL    = 2'd3
    } ch_ofs_e;

    localparam int SHARED_PEND_ADDR  = CH_N * REGS_PER_CH;
    localparam int ERRCNT_BASE       = SHARED_PEND_ADDR + 1;
    localparam int PEND_ERR_BIT      = 0;
    localparam int PEND_WAKE_BIT     = 1;
    localparam int CTRL_BERR_OFF_BIT = 0;

    typedef struct packed {
        logic wake;
        logic err;
    } shared_pend_t;

    function automatic logic [DATA_W-1:0] errcnt_word(
        input logic [ERRC_W-1:0] tec,
        input logic [ERRC_W-1:0] rec
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[ERRC_W-1:0]        = rec;
        w[2*ERRC_W-1:ERRC_W] = tec;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pend_word(input shared_pend_t p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PEND_ERR_BIT]  = p.err;
        w[PEND_WAKE_BIT] = p.wake;
        return w;
    endfunction

endpackage

// File: rtl/can_slot_tracker.sv
module can_slot_tracker #(
    parameter int SLOT_N = can_irq_pkg::SLOT_N,
    parameter int SLOT_W = $clog2(SLOT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic [SLOT_W-1:0] evt_slot,
    input  logic              clr_we,
    input  logic [SLOT_N-1:0] clr_mask,
    input  logic [SLOT_N-1:0] slot_en,
    output logic [SLOT_N-1:0] done_q,
    output logic              req
);

    logic [SLOT_N-1:0] set_vec;
    logic [SLOT_N-1:0] clr_vec;
    logic [SLOT_N-1:0] done_d;

    always_comb begin
        set_vec = evt ? (SLOT_N'(1) << evt_slot) : '0;
        clr_vec = clr_we ? clr_mask : '0;
        // set applied after clear so a same-cycle event survives
        done_d  = (done_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= '0;
        else     done_q <= done_d;
    end

    assign req = |(done_q & slot_en);

    assert_event_recorded_R1: assert property (@(posedge clk) disable iff (rst)
        evt |=> done_q[$past(evt_slot)]);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!evt && !clr_we) |=> $stable(done_q));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !evt) |=> ((done_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/can_err_wake.sv
module can_err_wake #(
    parameter int CH_N = can_irq_pkg::CH_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_N-1:0] passive_lvl,
    input  logic [CH_N-1:0] busoff_lvl,
    input  logic [CH_N-1:0] berr_pulse,
    input  logic [CH_N-1:0] berr_mute,
    input  logic [CH_N-1:0] wake_pulse,
    input  logic            low_power,
    input  logic            clr_we,
    input  logic            clr_err,
    input  logic            clr_wake,
    output can_irq_pkg::shared_pend_t pend_q
);
    import can_irq_pkg::*;

    logic [CH_N-1:0] passive_q;
    logic [CH_N-1:0] busoff_q;
    logic            err_set;
    logic            wake_set;
    shared_pend_t    pend_d;

    always_comb begin
        err_set  = |((passive_lvl & ~passive_q) |
                     (busoff_lvl  & ~busoff_q)  |
                     (berr_pulse  & ~berr_mute));
        wake_set = low_power & (|wake_pulse);
        pend_d.err  = err_set  | (pend_q.err  & ~(clr_we & clr_err));
        pend_d.wake = wake_set | (pend_q.wake & ~(clr_we & clr_wake));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            passive_q <= '0;
            busoff_q  <= '0;
            pend_q    <= '0;
        end else begin
            passive_q <= passive_lvl;
            busoff_q  <= busoff_lvl;
            pend_q    <= pend_d;
        end
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_chk
        assert_passive_entry_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(passive_lvl[c]) |=> pend_q.err);
        assert_busoff_entry_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(busoff_lvl[c]) |=> pend_q.err);
        assert_berr_unmuted_R5: assert property (@(posedge clk) disable iff (rst)
            (berr_pulse[c] && !berr_mute[c]) |=> pend_q.err);
    end

    assert_wake_set_R6: assert property (@(posedge clk) disable iff (rst)
        (low_power && (|wake_pulse)) |=> pend_q.wake);

    assert_wake_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (!low_power && !pend_q.wake) |=> !pend_q.wake);

endmodule

// File: rtl/can_irq_agg.sv
module can_irq_agg #(
    parameter int CH_N   = can_irq_pkg::CH_N,
    parameter int SLOT_N = can_irq_pkg::SLOT_N,
    parameter int DATA_W = can_irq_pkg::DATA_W,
    parameter int ADDR_W = can_irq_pkg::ADDR_W,
    parameter int ERRC_W = can_irq_pkg::ERRC_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CH_N-1:0]        tx_done,
    input  logic [CH_N*$clog2(SLOT_N)-1:0] tx_slot,
    input  logic [CH_N-1:0]        rx_done,
    input  logic [CH_N*$clog2(SLOT_N)-1:0] rx_slot,
    input  logic [CH_N-1:0]        err_passive,
    input  logic [CH_N-1:0]        bus_off,
    input  logic [CH_N-1:0]        bus_err,
    input  logic [CH_N-1:0]        wake_evt,
    input  logic                   low_power,
    input  logic [CH_N*ERRC_W-1:0] rx_err_cnt,
    input  logic [CH_N*ERRC_W-1:0] tx_err_cnt,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_we,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic [CH_N-1:0]        irq_tx,
    output logic [CH_N-1:0]        irq_rx,
    output logic                   irq_err,
    output logic                   irq_wake
);
    import can_irq_pkg::*;

    localparam int SW       = $clog2(SLOT_N);
    localparam int PEND_ADR = CH_N * REGS_PER_CH;
    localparam int CNT_ADR  = PEND_ADR + 1;

    logic [SLOT_N-1:0] slot_en  [CH_N];
    logic [SLOT_N-1:0] tx_st    [CH_N];
    logic [SLOT_N-1:0] rx_st    [CH_N];
    logic [CH_N-1:0]   berr_off;
    shared_pend_t      pend;

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        localparam int BASE = c * REGS_PER_CH;

        logic wr_en_reg, wr_tx, wr_rx, wr_ctrl;

        always_comb begin
            wr_en_reg = reg_we && (reg_addr == ADDR_W'(BASE + int'(OFS_SLOT_EN)));
            wr_tx     = reg_we && (reg_addr == ADDR_W'(BASE + int'(OFS_TX_DONE)));
            wr_rx     = reg_we && (reg_addr == ADDR_W'(BASE + int'(OFS_RX_DONE)));
            wr_ctrl   = reg_we && (reg_addr == ADDR_W'(BASE + int'(OFS_CTRL)));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_en[c]  <= '0;
                berr_off[c] <= 1'b0;
            end else begin
                if (wr_en_reg) slot_en[c]  <= reg_wdata[SLOT_N-1:0];
                if (wr_ctrl)   berr_off[c] <= reg_wdata[CTRL_BERR_OFF_BIT];
            end
        end

        can_slot_tracker #(.SLOT_N(SLOT_N), .SLOT_W(SW)) u_tx_trk (
            .clk      (clk),
            .rst      (rst),
            .evt      (tx_done[c]),
            .evt_slot (tx_slot[c*SW +: SW]),
            .clr_we   (wr_tx),
            .clr_mask (reg_wdata[SLOT_N-1:0]),
            .slot_en  (slot_en[c]),
            .done_q   (tx_st[c]),
            .req      (irq_tx[c])
        );

        can_slot_tracker #(.SLOT_N(SLOT_N), .SLOT_W(SW)) u_rx_trk (
            .clk      (clk),
            .rst      (rst),
            .evt      (rx_done[c]),
            .evt_slot (rx_slot[c*SW +: SW]),
            .clr_we   (wr_rx),
            .clr_mask (reg_wdata[SLOT_N-1:0]),
            .slot_en  (slot_en[c]),
            .done_q   (rx_st[c]),
            .req      (irq_rx[c])
        );
    end

    logic pend_wr;
    assign pend_wr = reg_we && (reg_addr == ADDR_W'(PEND_ADR));

    can_err_wake #(.CH_N(CH_N)) u_err_wake (
        .clk         (clk),
        .rst         (rst),
        .passive_lvl (err_passive),
        .busoff_lvl  (bus_off),
        .berr_pulse  (bus_err),
        .berr_mute   (berr_off),
        .wake_pulse  (wake_evt),
        .low_power   (low_power),
        .clr_we      (pend_wr),
        .clr_err     (reg_wdata[PEND_ERR_BIT]),
        .clr_wake    (reg_wdata[PEND_WAKE_BIT]),
        .pend_q      (pend)
    );

    assign irq_err  = pend.err;
    assign irq_wake = pend.wake;

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < CH_N; c++) begin
            if (reg_addr == ADDR_W'(c*REGS_PER_CH + int'(OFS_SLOT_EN)))
                reg_rdata = DATA_W'(slot_en[c]);
            if (reg_addr == ADDR_W'(c*REGS_PER_CH + int'(OFS_TX_DONE)))
                reg_rdata = DATA_W'(tx_st[c]);
            if (reg_addr == ADDR_W'(c*REGS_PER_CH + int'(OFS_RX_DONE)))
                reg_rdata = DATA_W'(rx_st[c]);
            if (reg_addr == ADDR_W'(c*REGS_PER_CH + int'(OFS_CTRL)))
                reg_rdata = DATA_W'(berr_off[c]) << CTRL_BERR_OFF_BIT;
            if (reg_addr == ADDR_W'(CNT_ADR + c))
                reg_rdata = errcnt_word(tx_err_cnt[c*ERRC_W +: ERRC_W],
                                        rx_err_cnt[c*ERRC_W +: ERRC_W]);
        end
        if (reg_addr == ADDR_W'(PEND_ADR))
            reg_rdata = pend_word(pend);
    end

    assert_req_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_en[0] == '0) |-> !irq_tx[0] && !irq_rx[0]);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_err && !pend_wr) |=> irq_err);

endmodule

// File: tb/can_irq_agg_bench.sv
module can_irq_agg_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  tx_done, rx_done, err_passive, bus_off, bus_err, wake_evt;
    logic [7:0]  tx_slot, rx_slot;
    logic        low_power;
    logic [15:0] rx_err_cnt, tx_err_cnt;
    logic [3:0]  reg_addr;
    logic        reg_we;
    logic [15:0] reg_wdata, reg_rdata;
    logic [1:0]  irq_tx, irq_rx;
    logic        irq_err, irq_wake;

    always #5 clk = ~clk;

    can_irq_agg u_can_irq_agg (
        .clk(clk), .rst(rst),
        .tx_done(tx_done), .tx_slot(tx_slot),
        .rx_done(rx_done), .rx_slot(rx_slot),
        .err_passive(err_passive), .bus_off(bus_off), .bus_err(bus_err),
        .wake_evt(wake_evt), .low_power(low_power),
        .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err), .irq_wake(irq_wake)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic       ch;
        logic       is_rx;
        logic [3:0] slot;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 4'd0},
        '{1'b0, 1'b1, 4'd15},
        '{1'b1, 1'b0, 4'd3},
        '{1'b1, 1'b1, 4'd9},
        '{1'b0, 1'b0, 4'd7},
        '{1'b1, 1'b1, 4'd2},
        '{1'b0, 1'b1, 4'd0},
        '{1'b1, 1'b0, 4'd12}
    };

    logic [15:0] m_tx [2];
    logic [15:0] m_rx [2];
    logic [15:0] m_en [2];

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic slot_evt(input int ch, input logic is_rx, input logic [3:0] s);
        @(negedge clk);
        if (is_rx) begin rx_done[ch] = 1'b1; rx_slot[ch*4 +: 4] = s; end
        else       begin tx_done[ch] = 1'b1; tx_slot[ch*4 +: 4] = s; end
        @(negedge clk);
        tx_done = '0; rx_done = '0;
    endtask

    task automatic pulse_berr(input int ch);
        @(negedge clk); bus_err[ch] = 1'b1;
        @(negedge clk); bus_err = '0;
    endtask

    task automatic pulse_wake(input int ch);
        @(negedge clk); wake_evt[ch] = 1'b1;
        @(negedge clk); wake_evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        rst = 1'b1;
        tx_done = '0; rx_done = '0; tx_slot = '0; rx_slot = '0;
        err_passive = '0; bus_off = '0; bus_err = '0; wake_evt = '0;
        low_power = 1'b0; rx_err_cnt = '0; tx_err_cnt = '0;
        reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        for (int i = 0; i < 2; i++) begin m_tx[i] = '0; m_rx[i] = '0; m_en[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 irq lines", {10'd0, irq_tx, irq_rx, irq_err, irq_wake}, 16'h0);
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            chk("R10 register reset", d, 16'h0);
        end

        // R9 enables are read/write
        m_en[0] = 16'hFFFF; m_en[1] = 16'h00FF;
        wr(4'd0, m_en[0]);
        wr(4'd4, m_en[1]);
        rd(4'd0, d); chk("R9 ch0 enable readback", d, m_en[0]);
        rd(4'd4, d); chk("R9 ch1 enable readback", d, m_en[1]);

        // R1/R2 vector walk
        for (int v = 0; v < 8; v++) begin
            int c;
            c = int'(VECS[v].ch);
            slot_evt(c, VECS[v].is_rx, VECS[v].slot);
            if (VECS[v].is_rx) m_rx[c] = m_rx[c] | (16'h1 << VECS[v].slot);
            else               m_tx[c] = m_tx[c] | (16'h1 << VECS[v].slot);
            rd(4'(c*4 + 1), d); chk("R1 tx completion", d, m_tx[c]);
            rd(4'(c*4 + 2), d); chk("R1 rx completion", d, m_rx[c]);
            chk("R2 irq_tx", {15'd0, irq_tx[c]}, {15'd0, |(m_tx[c] & m_en[c])});
            chk("R2 irq_rx", {15'd0, irq_rx[c]}, {15'd0, |(m_rx[c] & m_en[c])});
        end

        // R2 disable drops line, keeps completion
        wr(4'd0, 16'h0);
        @(negedge clk);
        chk("R2 disabled tx line", {15'd0, irq_tx[0]}, 16'h0);
        rd(4'd1, d); chk("R2 completion kept", d, m_tx[0]);
        wr(4'd0, 16'hFFFF);
        chk("R2 re-enabled tx line", {15'd0, irq_tx[0]}, 16'h1);

        // R3 write-one-to-clear
        wr(4'd1, 16'h0001);
        m_tx[0] = m_tx[0] & ~16'h0001;
        rd(4'd1, d); chk("R3 w1c single bit", d, m_tx[0]);
        wr(4'd1, 16'h0000);
        rd(4'd1, d); chk("R3 zero write no effect", d, m_tx[0]);
        // same-cycle set and clear of slot 5
        @(negedge clk);
        tx_done[0] = 1'b1; tx_slot[3:0] = 4'd5;
        reg_addr = 4'd1; reg_wdata = 16'h0020; reg_we = 1'b1;
        @(negedge clk);
        tx_done = '0; reg_we = 1'b0;
        m_tx[0] = m_tx[0] | 16'h0020;
        rd(4'd1, d); chk("R3 set wins", d, m_tx[0]);
        wr(4'd1, 16'hFFFF); wr(4'd2, 16'hFFFF);
        wr(4'd5, 16'hFFFF); wr(4'd6, 16'hFFFF);
        chk("R3 all cleared lines", {12'd0, irq_tx, irq_rx}, 16'h0);

        // R4 level edges
        @(negedge clk); err_passive[0] = 1'b1;
        @(negedge clk);
        chk("R4 passive entry", {15'd0, irq_err}, 16'h1);
        wr(4'd8, 16'h0001);
        repeat (4) @(negedge clk);
        chk("R4 held level no retrigger", {15'd0, irq_err}, 16'h0);
        err_passive[0] = 1'b0;
        @(negedge clk); bus_off[1] = 1'b1;
        @(negedge clk);
        chk("R4 busoff entry", {15'd0, irq_err}, 16'h1);
        wr(4'd8, 16'h0001);
        bus_off[1] = 1'b0;

        // R5 bus error and its mute
        pulse_berr(1);
        chk("R5 bus error raises", {15'd0, irq_err}, 16'h1);
        wr(4'd8, 16'h0001);
        wr(4'd7, 16'h0001);
        rd(4'd7, d); chk("R5 ctrl readback", d, 16'h0001);
        pulse_berr(1);
        rd(4'd8, d); chk("R5 muted bus error", d, 16'h0);
        pulse_berr(0);
        chk("R5 other channel unmuted", {15'd0, irq_err}, 16'h1);
        wr(4'd8, 16'h0001);

        // R6 wake gating
        pulse_wake(0);
        rd(4'd8, d); chk("R6 wake ignored awake", d, 16'h0);
        low_power = 1'b1;
        pulse_wake(1);
        rd(4'd8, d); chk("R6 wake in low power", d, 16'h0002);

        // R7 set wins on shared pending
        @(negedge clk);
        wake_evt[0] = 1'b1;
        reg_addr = 4'd8; reg_wdata = 16'h0002; reg_we = 1'b1;
        @(negedge clk);
        wake_evt = '0; reg_we = 1'b0;
        chk("R7 wake set wins", {15'd0, irq_wake}, 16'h1);
        wr(4'd8, 16'h0002);
        chk("R7 wake cleared", {15'd0, irq_wake}, 16'h0);
        low_power = 1'b0;

        // R8 counters
        @(negedge clk);
        rx_err_cnt = 16'hA512; tx_err_cnt = 16'h7F3C;
        rd(4'd9, d);  chk("R8 ch0 counters", d, 16'h3C12);
        rd(4'd10, d); chk("R8 ch1 counters", d, 16'h7FA5);

        // R9 unmapped and side-effect-free reads
        rd(4'd15, d); chk("R9 unmapped reads zero", d, 16'h0);
        slot_evt(1, 1'b0, 4'd4);
        rd(4'd5, d); chk("R9 read first", d, 16'h0010);
        @(negedge clk);
        rd(4'd5, d); chk("R9 read again unchanged", d, 16'h0010);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule